// File: doc/BRIEF.md
# Secure FPU Access Gating Unit

This block holds three control registers that decide whether software may use the floating-point unit. The first is a secure-only access register, whose bit 10 grants the FPU to non-secure software. The second is a coprocessor access register, which holds the ordinary per-level FPU permission field. The third is a hypervisor trap register, whose bits can send FPU use to level 2. When the secure-only bit is clear and the requester is non-secure, certain fields of the other two registers are masked. The coprocessor permission nibble reads as zeros and ignores writes. The hypervisor trap pair reads as ones and ignores writes. In the same state, FPU instructions at level 2 or below are forced to trap.

Software reaches the registers through a single-cycle port. A 2-bit address picks a register, a write strobe commits on the rising clock edge, and read data is combinational. The port also carries a secure-state flag and the current privilege level. From these, a trap level output reports where a floating-point instruction would trap, with 0 meaning no trap. Parameters select whether gating exists at all. It is active only when the highest privilege level is present and runs in 32-bit mode.

Top module: `fpu_sec_gate`

## Requirements
- R1: After synchronous active-high reset, all three registers read zero from secure state.
- R2: The secure access register (address 0) is written only when `secure` is 1. A non-secure write to it leaves it unchanged.
- R3: While gated, a non-secure read of the coprocessor access register (address 1) returns bits [23:20] as zero. Gated means `secure`=0, bit 10 of the secure access register is 0, and gating is built in.
- R4: While gated, a non-secure write to address 1 keeps stored bits [23:20]. All other bits take the written data.
- R5: While gated, a non-secure read of the hypervisor trap register (address 2) returns bits [11:10] as ones.
- R6: While gated, a non-secure write to address 2 keeps stored bits [11:10]. All other bits are updated.
- R7: Secure accesses, and non-secure accesses while bit 10 of the secure access register is 1, read and write all bits without masking.
- R8: While gated, if `cur_el` is 2 or below, `trap_el` is 2 when `cur_el` is 2 and 1 otherwise. This rule takes priority over R9 and R10.
- R9: When not gated and `cur_el` is 0 or 1, a stored field value at bits [21:20] of address 1 other than 0b11 gives `trap_el` = 1.
- R10: When not gated and R9 does not trap, a non-secure request at `cur_el` 2 or below with stored bit 10 of address 2 set gives `trap_el` = 2. All other cases, including `cur_el` 3, give 0.
- R11: When built without the highest level, or with it in 64-bit mode, no masking or forced trap occurs.
- R12: Address 3 reads zero, and writes to it change no register.
- R13: Read data and `trap_el` reflect a write only after the clock edge that commits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, committed on the rising edge |
| addr | input | 2 | Register select: 0 secure access, 1 coprocessor access, 2 hypervisor trap, 3 unmapped |
| wdata | input | 32 | Write data |
| secure | input | 1 | Requester is in secure state |
| cur_el | input | 2 | Current privilege level, 0 to 3 |
| rdata | output | 32 | Gated read data |
| trap_el | output | 2 | Level an FPU instruction traps to; 0 means no trap |

## Verification
On every cycle, the assertions check that protected fields hold across gated writes and that non-secure writes leave the secure access register alone. They also check that gated reads show the masked values, and that the forced trap levels and the level-3 no-trap case hold. Only the bench scenarios can show the interaction over time: a field written in secure state survives a later non-secure write, and access reopens once the enable bit is set. A second instance, built without gating, shows that the same stimulus leaves every field unmasked there.

// File: rtl/fpu_gate_pkg.sv
package fpu_gate_pkg;
   typedef enum logic [1:0] {
      SEL_SAC   = 2'd0,
      SEL_CPAC  = 2'd1,
      SEL_HTRAP = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   localparam logic [1:0] LVL_NONE = 2'd0;
   localparam logic [1:0] LVL_1    = 2'd1;
   localparam logic [1:0] LVL_2    = 2'd2;
   localparam logic [1:0] LVL_3    = 2'd3;
   localparam logic [1:0] FIELD_FULL = 2'b11;
endpackage

// File: rtl/fpu_gate_preg.sv
module fpu_gate_preg #(
   parameter int          DATA_W  = 32,
   parameter logic [63:0] RST_VAL = 64'd0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [DATA_W-1:0] keep_mask,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam logic [DATA_W-1:0] RST_Q = RST_VAL[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (rst)     q <= RST_Q;
      else if (we) q <= (wdata & ~keep_mask) | (q & keep_mask);
   end

   // R4 / R6: bits under the keep mask survive the write
   a_r6_keep_bits: assert property (@(posedge clk) disable iff (rst)
      we |=> ((q & $past(keep_mask)) == ($past(q) & $past(keep_mask))));

   // R13: no strobe, no change
   a_r13_hold: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(q));
endmodule

// File: rtl/fpu_gate_rdview.sv
module fpu_gate_rdview
   import fpu_gate_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CP_LO  = 20,
   parameter int CP_HI  = 23,
   parameter int HT_LO  = 10,
   parameter int HT_HI  = 11
) (
   input  logic [1:0]        sel,
   input  logic              gated,
   input  logic [DATA_W-1:0] sac_q,
   input  logic [DATA_W-1:0] cpac_q,
   input  logic [DATA_W-1:0] htrap_q,
   output logic [DATA_W-1:0] rdata
);
   localparam int CP_W = CP_HI - CP_LO + 1;
   localparam int HT_W = HT_HI - HT_LO + 1;
   localparam logic [DATA_W-1:0] CP_MASK = DATA_W'(((64'd1 << CP_W) - 64'd1) << CP_LO);
   localparam logic [DATA_W-1:0] HT_MASK = DATA_W'(((64'd1 << HT_W) - 64'd1) << HT_LO);

   logic [DATA_W-1:0] cp_view, ht_view;

   always_comb begin
      cp_view = gated ? (cpac_q & ~CP_MASK) : cpac_q;
      ht_view = gated ? (htrap_q | HT_MASK) : htrap_q;
      unique case (reg_sel_e'(sel))
         SEL_SAC:   rdata = sac_q;
         SEL_CPAC:  rdata = cp_view;
         SEL_HTRAP: rdata = ht_view;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/fpu_gate_trapsel.sv
module fpu_gate_trapsel
   import fpu_gate_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] cur_el,
   input  logic       secure,
   input  logic       gated,
   input  logic [1:0] cp_field,
   input  logic       ht_bit,
   output logic [1:0] trap_el
);
   logic low_lvl, below3;

   always_comb begin
      low_lvl = (cur_el == LVL_NONE) || (cur_el == LVL_1);
      below3  = (cur_el != LVL_3);
      trap_el = LVL_NONE;
      if (gated && below3)
         trap_el = (cur_el == LVL_2) ? LVL_2 : LVL_1;
      else if (low_lvl && (cp_field != FIELD_FULL))
         trap_el = LVL_1;
      else if (below3 && !secure && ht_bit)
         trap_el = LVL_2;
   end

   a_r8_gate_el2: assert property (@(posedge clk) disable iff (rst)
      (gated && cur_el == LVL_2) |-> (trap_el == LVL_2));

   a_r8_gate_low: assert property (@(posedge clk) disable iff (rst)
      (gated && cur_el != LVL_2 && cur_el != LVL_3) |-> (trap_el == LVL_1));

   a_r10_top_level: assert property (@(posedge clk) disable iff (rst)
      (cur_el == LVL_3) |-> (trap_el == LVL_NONE));
endmodule

// File: rtl/fpu_sec_gate.sv
module fpu_sec_gate
   import fpu_gate_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int EN_BIT    = 10,
   parameter int CP_LO     = 20,
   parameter int CP_HI     = 23,
   parameter int HT_LO     = 10,
   parameter int HT_HI     = 11,
   parameter bit HAS_TOP   = 1'b1,
   parameter bit TOP_IS_64 = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              secure,
   input  logic [1:0]        cur_el,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        trap_el
);
   localparam int  CP_W     = CP_HI - CP_LO + 1;
   localparam int  HT_W     = HT_HI - HT_LO + 1;
   localparam bit  GATE_ON  = HAS_TOP && !TOP_IS_64;
   localparam logic [DATA_W-1:0] CP_MASK = DATA_W'(((64'd1 << CP_W) - 64'd1) << CP_LO);
   localparam logic [DATA_W-1:0] HT_MASK = DATA_W'(((64'd1 << HT_W) - 64'd1) << HT_LO);

   generate
      if (DATA_W < 2 || DATA_W > 64)         begin : g_bad_w  $error("DATA_W out of range"); end
      if (EN_BIT >= DATA_W)                  begin : g_bad_en $error("EN_BIT outside word"); end
      if (CP_HI < CP_LO + 1 || CP_HI >= DATA_W) begin : g_bad_cp $error("bad permission field"); end
      if (HT_HI < HT_LO || HT_HI >= DATA_W)  begin : g_bad_ht $error("bad trap field"); end
   endgenerate

   logic [DATA_W-1:0] sac_q, cpac_q, htrap_q;
   logic              gated;
   logic              we_sac, we_cpac, we_htrap;
   logic [DATA_W-1:0] keep_cp, keep_ht;

   generate
      if (GATE_ON) begin : g_gate
         assign gated = !secure && !sac_q[EN_BIT];
      end else begin : g_nogate
         assign gated = 1'b0;
      end
   endgenerate

   always_comb begin
      we_sac   = wr_en && (addr == SEL_SAC) && secure;
      we_cpac  = wr_en && (addr == SEL_CPAC);
      we_htrap = wr_en && (addr == SEL_HTRAP);
      keep_cp  = gated ? CP_MASK : '0;
      keep_ht  = gated ? HT_MASK : '0;
   end

   fpu_gate_preg #(.DATA_W(DATA_W)) u_sac (
      .clk(clk), .rst(rst), .we(we_sac), .keep_mask('0),
      .wdata(wdata), .q(sac_q));

   fpu_gate_preg #(.DATA_W(DATA_W)) u_cpac (
      .clk(clk), .rst(rst), .we(we_cpac), .keep_mask(keep_cp),
      .wdata(wdata), .q(cpac_q));

   fpu_gate_preg #(.DATA_W(DATA_W)) u_htrap (
      .clk(clk), .rst(rst), .we(we_htrap), .keep_mask(keep_ht),
      .wdata(wdata), .q(htrap_q));

   fpu_gate_rdview #(
      .DATA_W(DATA_W), .CP_LO(CP_LO), .CP_HI(CP_HI), .HT_LO(HT_LO), .HT_HI(HT_HI)
   ) u_view (
      .sel(addr), .gated(gated), .sac_q(sac_q), .cpac_q(cpac_q),
      .htrap_q(htrap_q), .rdata(rdata));

   fpu_gate_trapsel u_trap (
      .clk(clk), .rst(rst), .cur_el(cur_el), .secure(secure), .gated(gated),
      .cp_field(cpac_q[CP_LO+1:CP_LO]), .ht_bit(htrap_q[HT_LO]),
      .trap_el(trap_el));

   // R2: non-secure writes never reach the secure access register
   a_r2_ns_sac_hold: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == SEL_SAC && !secure) |=> $stable(sac_q));

   // R12: unmapped address reads zero
   a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
      (addr == SEL_NONE) |-> (rdata == '0));

   generate
      if (GATE_ON) begin : g_chk_gate
         a_r3_ns_cp_zero: assert property (@(posedge clk) disable iff (rst)
            (!secure && !sac_q[EN_BIT] && addr == SEL_CPAC) |-> (rdata[CP_HI:CP_LO] == '0));
         a_r5_ns_ht_ones: assert property (@(posedge clk) disable iff (rst)
            (!secure && !sac_q[EN_BIT] && addr == SEL_HTRAP) |-> (&rdata[HT_HI:HT_LO]));
      end else begin : g_chk_nogate
         a_r11_plain_cp: assert property (@(posedge clk) disable iff (rst)
            (addr == SEL_CPAC) |-> (rdata == cpac_q));
      end
   endgenerate
endmodule

// File: tb/test_fpu_sec_gate.sv
module test_fpu_sec_gate;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic        secure = 1'b1;
   logic [1:0]  cur_el = 2'd1;
   logic [31:0] rdata_a, rdata_b;
   logic [1:0]  trap_a, trap_b;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference state: a = gating built in, b = gating absent
   logic [31:0] ma_sac, ma_cp, ma_ht, mb_sac, mb_cp, mb_ht;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpu_sec_gate i_fpu_sec_gate (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .secure(secure), .cur_el(cur_el), .rdata(rdata_a), .trap_el(trap_a));

   fpu_sec_gate #(.HAS_TOP(1'b0)) i_nogate (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .secure(secure), .cur_el(cur_el), .rdata(rdata_b), .trap_el(trap_b));

   function automatic bit is_gated(bit has, bit sec, logic [31:0] sac);
      return has && !sec && !sac[10];
   endfunction

   function automatic logic [31:0] ref_read(bit g, logic [1:0] a,
         logic [31:0] sac, logic [31:0] cp, logic [31:0] ht);
      if (a == 2'd0) return sac;
      if (a == 2'd1) return g ? (cp & 32'hFF0F_FFFF) : cp;
      if (a == 2'd2) return g ? (ht | 32'h0000_0C00) : ht;
      return 32'h0;
   endfunction

   function automatic logic [1:0] ref_trap(bit g, bit sec, logic [1:0] el,
         logic [31:0] cp, logic [31:0] ht);
      if (el == 2'd3) return 2'd0;
      if (g) return (el == 2'd2) ? 2'd2 : 2'd1;
      if (el <= 2'd1 && cp[21:20] != 2'b11) return 2'd1;
      if (!sec && ht[10]) return 2'd2;
      return 2'd0;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic op(string tag, bit w, logic [1:0] a, logic [31:0] d, bit s, logic [1:0] el);
      bit ga, gb;
      @(negedge clk);
      wr_en = w; addr = a; wdata = d; secure = s; cur_el = el;
      #1;
      ga = is_gated(1'b1, s, ma_sac);
      gb = is_gated(1'b0, s, mb_sac);
      check(tag, rdata_a, ref_read(ga, a, ma_sac, ma_cp, ma_ht));
      check(tag, {30'd0, trap_a}, {30'd0, ref_trap(ga, s, el, ma_cp, ma_ht)});
      check("R11", rdata_b, ref_read(gb, a, mb_sac, mb_cp, mb_ht));
      check("R11", {30'd0, trap_b}, {30'd0, ref_trap(gb, s, el, mb_cp, mb_ht)});
      if (w) begin
         if (a == 2'd0 && s) begin ma_sac = d; mb_sac = d; end
         if (a == 2'd1) begin
            ma_cp = ga ? ((d & 32'hFF0F_FFFF) | (ma_cp & 32'h00F0_0000)) : d;
            mb_cp = d;
         end
         if (a == 2'd2) begin
            ma_ht = ga ? ((d & 32'hFFFF_F3FF) | (ma_ht & 32'h0000_0C00)) : d;
            mb_ht = d;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      ma_sac = 0; ma_cp = 0; ma_ht = 0; mb_sac = 0; mb_cp = 0; mb_ht = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R1: reset values, secure view
      op("R1", 0, 2'd0, 0, 1, 2'd1);
      op("R1", 0, 2'd1, 0, 1, 2'd1);
      op("R1", 0, 2'd2, 0, 1, 2'd3);
      // R7: secure writes unmasked; R13: new value only after the edge
      op("R7", 1, 2'd1, 32'hFFFF_FFFF, 1, 2'd1);
      op("R13", 0, 2'd1, 0, 1, 2'd1);
      // R3: non-secure gated read hides the nibble; R8 gated traps
      op("R3", 0, 2'd1, 0, 0, 2'd1);
      op("R8", 0, 2'd1, 0, 0, 2'd0);
      op("R8", 0, 2'd1, 0, 0, 2'd2);
      op("R10", 0, 2'd1, 0, 0, 2'd3);
      // R4: gated write keeps the nibble
      op("R4", 1, 2'd1, 32'h0000_0000, 0, 2'd1);
      op("R4", 0, 2'd1, 0, 1, 2'd1);
      // R5 / R6 on the hypervisor trap register
      op("R5", 0, 2'd2, 0, 0, 2'd2);
      op("R6", 1, 2'd2, 32'hFFFF_FFFF, 0, 2'd2);
      op("R6", 0, 2'd2, 0, 1, 2'd3);
      // R12: unmapped address
      op("R12", 1, 2'd3, 32'hDEAD_BEEF, 1, 2'd1);
      op("R12", 0, 2'd3, 0, 0, 2'd1);
      op("R12", 0, 2'd1, 0, 1, 2'd1);
      // R2: non-secure write to the enable register is dropped
      op("R2", 1, 2'd0, 32'h0000_0400, 0, 2'd1);
      op("R2", 0, 2'd0, 0, 1, 2'd1);
      // R7: open access, then non-secure accesses are unmasked
      op("R7", 1, 2'd0, 32'h0000_0400, 1, 2'd1);
      op("R7", 0, 2'd1, 0, 0, 2'd1);
      op("R7", 1, 2'd1, 32'h0030_0000, 0, 2'd1);
      op("R9", 0, 2'd1, 0, 0, 2'd1);
      op("R9", 0, 2'd1, 0, 0, 2'd0);
      op("R7", 1, 2'd2, 32'h0000_0000, 0, 2'd2);
      op("R10", 0, 2'd2, 0, 0, 2'd1);
      op("R7", 1, 2'd2, 32'h0000_0400, 0, 2'd2);
      op("R10", 0, 2'd2, 0, 0, 2'd0);
      op("R10", 0, 2'd2, 0, 0, 2'd2);
      op("R10", 0, 2'd2, 0, 1, 2'd1);
      op("R9", 1, 2'd1, 32'h0010_0000, 1, 2'd1);
      op("R9", 0, 2'd1, 0, 0, 2'd1);
      // pseudo-random traffic against the model
      lf = 32'h1ACE_B00C;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         op("R13", lf[0], lf[2:1], {lf[15:0], lf[31:16]}, lf[3], lf[5:4]);
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule